// File: doc/BRIEF.md
# SMBus Target Register Bridge

This block turns a series of SMBus write transactions into one internal dword access. A byte-level SMBus target front end handles the wire protocol. It passes each received byte, the start and stop events and the read-byte requests to the bridge, and it takes back ack/nack decisions and a clock-stretch request. The bridge collects the parameters of a configuration or memory access over one or more writes, and it launches the access when a write whose command byte has the End flag completes the parameter set. It holds the bus clock low until the internal response or a timeout arrives, then acks or nacks that final byte.

A later SMBus read returns a status byte, which describes the outcome of the last internal access. Four bytes of data from the last successful internal read follow it. The internal side is a single-outstanding request/response bus with a one-cycle request pulse.

Top module: `smb_reg_bridge`

## Requirements
- R1: Configuration access (command space field bits 3:2 = 00): the first parameter byte is register bits 7:0. The low nibble of the second byte is register bits 11:8 and its upper nibble is ignored. The request shows space 00 and destination 0.
- R2: Memory access (space 01): the first parameter byte is the destination. Three offset bytes follow, most significant first. The request address is the low 12 bits of the offset, and the upper 12 bits are dropped.
- R3: Parameters build up across any number of writes. The first byte of each write is the command byte. With command bit 6 set (block form), the byte after the command is a length and is not stored. Without End (bit 7), no request is issued and every byte is acked one cycle after it arrives.
- R4: The request is issued on the End write, on the byte that brings the stored count to what the access needs: 2 (config read), 6 (config write), 4 (memory read) or 8 (memory write). This may be the command byte itself. Command bit 0 = 1 means read. Write data follows the address bytes, least significant byte first. The request is a one-cycle pulse two cycles after that byte.
- R5: From the cycle after the launching byte, the stretch output is high until the ack for that byte. The ack comes one cycle after the internal response and never while stretch is high.
- R6: Response error code 00 acks the final byte and sets status 0x01. Code 01 (target abort) sets status 0x10, and codes 10 and 11 (master abort) set status 0x20. Both abort cases nack the final byte.
- R7: If no response comes within the timeout window (default 2 ms of clock, a parameter), the access is abandoned. The final byte is nacked TMO+2 cycles after it arrived, and the status becomes 0x80.
- R8: A command byte whose read/write bit differs from the one latched for the ongoing setup is nacked, and all stored parameters are discarded. A command byte with space bit 3 set is also nacked. Later bytes of the same write are nacked.
- R9: An SMBus read returns the status byte first, then the last successful internal read data, least significant byte first. Bytes requested beyond those five read 0xFF. Each byte appears one cycle after its request.
- R10: After the host nacks a read byte, the bridge stops supplying data: further byte requests return 0xFF until a new read starts.
- R11: After reset there is no request, no stretch and no ack, and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_start | input | 1 | Start/address phase pulse of a transaction |
| fe_rd_dir | input | 1 | With fe_start: 1 = SMBus read transaction |
| fe_stop | input | 1 | Stop condition pulse |
| fe_byte_vld | input | 1 | A written byte has been received |
| fe_byte | input | 8 | Received byte |
| fe_ack_vld | output | 1 | Ack decision for the last received byte is ready |
| fe_ack_nack | output | 1 | With fe_ack_vld: 1 = NACK |
| fe_stretch | output | 1 | Hold the bus clock low |
| fe_rd_req | input | 1 | Front end needs the next byte to transmit |
| fe_host_nack | input | 1 | Host nacked the byte just sent |
| fe_tx_vld | output | 1 | fe_tx_byte is valid |
| fe_tx_byte | output | 8 | Byte to transmit |
| ib_req_vld | output | 1 | Internal request pulse |
| ib_req_we | output | 1 | 1 = internal write |
| ib_req_space | output | 2 | 00 configuration, 01 memory |
| ib_req_dest | output | 8 | Destination memory (0 for configuration) |
| ib_req_addr | output | 12 | Register number or offset |
| ib_req_wdata | output | 32 | Write data |
| ib_rsp_vld | input | 1 | Internal response pulse |
| ib_rsp_err | input | 2 | 00 ok, 01 target abort, 1x master abort |
| ib_rsp_rdata | input | 32 | Read data |

## Verification
The assertions take three things about the inputs for granted. The front end delivers no byte while stretch is high or a decision is pending. The internal side answers each request at most once, and only after the request pulse. Byte requests and received bytes never fall in the same cycle. The stimulus meets all three because it drives the front end through tasks that wait for each ack or transmit byte before the next event. A single responder model returns one answer a fixed delay after each request pulse, or none at all in the timeout case.

// File: rtl/smb_bridge_pkg.sv
package smb_bridge_pkg;
  localparam int CMD_END_BIT = 7;
  localparam int CMD_BLK_BIT = 6;
  localparam int CMD_RES_BIT = 3;
  localparam int CMD_SP_LO   = 2;
  localparam int CMD_RD_BIT  = 0;

  localparam int CFG_ABYTES  = 2;
  localparam int MEM_ABYTES  = 4;
  localparam int DATA_BYTES  = 4;
  localparam int PRM_MAX     = MEM_ABYTES + DATA_BYTES;
  localparam int ADDR_W      = 12;

  typedef enum logic [1:0] {
    SP_CFG = 2'b00,
    SP_MEM = 2'b01
  } space_e;

  localparam logic [1:0] ERR_OK = 2'b00;
  localparam logic [1:0] ERR_TA = 2'b01;

  localparam logic [7:0] ST_OK  = 8'h01;
  localparam logic [7:0] ST_TA  = 8'h10;
  localparam logic [7:0] ST_MA  = 8'h20;
  localparam logic [7:0] ST_TMO = 8'h80;

  function automatic int need_bytes(input logic [1:0] sp, input logic rd);
    int n;
    n = (sp == SP_MEM) ? MEM_ABYTES : CFG_ABYTES;
    if (!rd) n = n + DATA_BYTES;
    return n;
  endfunction
endpackage

// File: rtl/smb_setup_collect.sv
module smb_setup_collect
  import smb_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_edge,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  output logic              byte_ack,
  output logic              byte_nack,
  output logic              fire_q,
  output logic              f_we,
  output logic [1:0]        f_space,
  output logic [7:0]        f_dest,
  output logic [ADDR_W-1:0] f_addr,
  output logic [31:0]       f_wdata
);
  localparam int CW = $clog2(PRM_MAX + 1);
  localparam int PW = $clog2(PRM_MAX);

  logic          seq_act_q, seq_act_d;
  logic          seq_rd_q, seq_rd_d;
  logic [1:0]    seq_sp_q, seq_sp_d;
  logic          tr_end_q, tr_end_d;
  logic          tr_blk_q, tr_blk_d;
  logic          tr_rej_q, tr_rej_d;
  logic [1:0]    pos_q, pos_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    prm_q [PRM_MAX];
  logic [7:0]    prm_d [PRM_MAX];
  logic          fire_d;
  logic          nack_c;

  always_comb begin
    seq_act_d = seq_act_q;
    seq_rd_d  = seq_rd_q;
    seq_sp_d  = seq_sp_q;
    tr_end_d  = tr_end_q;
    tr_blk_d  = tr_blk_q;
    tr_rej_d  = tr_rej_q;
    pos_d     = pos_q;
    cnt_d     = cnt_q;
    prm_d     = prm_q;
    fire_d    = 1'b0;
    nack_c    = 1'b0;
    if (frame_edge) begin
      pos_d    = '0;
      tr_end_d = 1'b0;
      tr_blk_d = 1'b0;
      tr_rej_d = 1'b0;
    end else if (byte_vld) begin
      if (pos_q != 2'd3) pos_d = pos_q + 2'd1;
      if (tr_rej_q) begin
        nack_c = 1'b1;
      end else if (pos_q == 2'd0) begin
        if ((seq_act_q && (byte_in[CMD_RD_BIT] != seq_rd_q)) || byte_in[CMD_RES_BIT]) begin
          nack_c    = 1'b1;
          tr_rej_d  = 1'b1;
          seq_act_d = 1'b0;
          cnt_d     = '0;
        end else begin
          seq_act_d = 1'b1;
          seq_rd_d  = byte_in[CMD_RD_BIT];
          seq_sp_d  = byte_in[CMD_SP_LO+1:CMD_SP_LO];
          tr_end_d  = byte_in[CMD_END_BIT];
          tr_blk_d  = byte_in[CMD_BLK_BIT];
          if (byte_in[CMD_END_BIT] &&
              int'(cnt_q) >= need_bytes(byte_in[CMD_SP_LO+1:CMD_SP_LO], byte_in[CMD_RD_BIT]))
            fire_d = 1'b1;
        end
      end else if (!(tr_blk_q && pos_q == 2'd1)) begin
        if (int'(cnt_q) < PRM_MAX) begin
          prm_d[cnt_q[PW-1:0]] = byte_in;
          cnt_d = cnt_q + CW'(1);
        end
        if (tr_end_q && (int'(cnt_q) + 1) >= need_bytes(seq_sp_q, seq_rd_q))
          fire_d = 1'b1;
      end
      if (fire_d) begin
        seq_act_d = 1'b0;
        cnt_d     = '0;
        tr_rej_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_act_q <= 1'b0;
      seq_rd_q  <= 1'b0;
      seq_sp_q  <= '0;
      tr_end_q  <= 1'b0;
      tr_blk_q  <= 1'b0;
      tr_rej_q  <= 1'b0;
      pos_q     <= '0;
      cnt_q     <= '0;
      fire_q    <= 1'b0;
      for (int i = 0; i < PRM_MAX; i++) prm_q[i] <= '0;
    end else begin
      seq_act_q <= seq_act_d;
      seq_rd_q  <= seq_rd_d;
      seq_sp_q  <= seq_sp_d;
      tr_end_q  <= tr_end_d;
      tr_blk_q  <= tr_blk_d;
      tr_rej_q  <= tr_rej_d;
      pos_q     <= pos_d;
      cnt_q     <= cnt_d;
      fire_q    <= fire_d;
      prm_q     <= prm_d;
    end
  end

  assign byte_ack  = byte_vld && !frame_edge && !fire_d;
  assign byte_nack = nack_c;

  // Field extraction from the stored parameter bytes
  logic is_mem;
  assign is_mem  = (seq_sp_q == SP_MEM);
  assign f_we    = !seq_rd_q;
  assign f_space = seq_sp_q;
  assign f_dest  = is_mem ? prm_q[0] : 8'h00;
  assign f_addr  = is_mem ? {prm_q[MEM_ABYTES-2][3:0], prm_q[MEM_ABYTES-1]}
                          : {prm_q[1][3:0], prm_q[0]};

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_wd
    assign f_wdata[8*g +: 8] = is_mem ? prm_q[MEM_ABYTES + g] : prm_q[CFG_ABYTES + g];
  end

  p_fire_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (cnt_q == '0) && !seq_act_q);
  p_reject_nacks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_rej_q && byte_vld && !frame_edge) |-> byte_nack);
endmodule

// File: rtl/smb_access_ctl.sv
module smb_access_ctl
  import smb_bridge_pkg::*;
#(
  parameter int TMO_CYC = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              f_we,
  input  logic [1:0]        f_space,
  input  logic [7:0]        f_dest,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [31:0]       f_wdata,
  input  logic              rsp_vld,
  input  logic [1:0]        rsp_err,
  input  logic [31:0]       rsp_rdata,
  output logic              req_vld,
  output logic              req_we,
  output logic [1:0]        req_space,
  output logic [7:0]        req_dest,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_nack,
  output logic [7:0]        status,
  output logic [31:0]       rdata
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic              busy_q, busy_d;
  logic              rv_q, rv_d;
  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic              done_q, done_d;
  logic              dn_q, dn_d;
  logic [7:0]        st_q, st_d;
  logic [31:0]       rd_q, rd_d;
  logic              we_q;
  logic [1:0]        sp_q;
  logic [7:0]        dst_q;
  logic [ADDR_W-1:0] ad_q;
  logic [31:0]       wd_q;

  always_comb begin
    busy_d = busy_q;
    rv_d   = 1'b0;
    tcnt_d = tcnt_q;
    done_d = 1'b0;
    dn_d   = 1'b0;
    st_d   = st_q;
    rd_d   = rd_q;
    if (fire) begin
      busy_d = 1'b1;
      rv_d   = 1'b1;
      tcnt_d = '0;
    end else if (busy_q) begin
      if (rsp_vld) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        if (rsp_err == ERR_OK) begin
          st_d = ST_OK;
          if (!we_q) rd_d = rsp_rdata;
        end else begin
          dn_d = 1'b1;
          st_d = (rsp_err == ERR_TA) ? ST_TA : ST_MA;
        end
      end else if (int'(tcnt_q) == TMO_CYC - 1) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        dn_d   = 1'b1;
        st_d   = ST_TMO;
      end else begin
        tcnt_d = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rv_q   <= 1'b0;
      tcnt_q <= '0;
      done_q <= 1'b0;
      dn_q   <= 1'b0;
      st_q   <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rv_q   <= rv_d;
      tcnt_q <= tcnt_d;
      done_q <= done_d;
      dn_q   <= dn_d;
      st_q   <= st_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      sp_q  <= '0;
      dst_q <= '0;
      ad_q  <= '0;
      wd_q  <= '0;
    end else if (fire) begin
      we_q  <= f_we;
      sp_q  <= f_space;
      dst_q <= f_dest;
      ad_q  <= f_addr;
      wd_q  <= f_wdata;
    end
  end

  assign req_vld   = rv_q;
  assign req_we    = we_q;
  assign req_space = sp_q;
  assign req_dest  = dst_q;
  assign req_addr  = ad_q;
  assign req_wdata = wd_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign done_nack = dn_q;
  assign status    = st_q;
  assign rdata     = rd_q;

  p_fire_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy_q);
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);
  p_tmo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> int'(tcnt_q) < TMO_CYC);
  p_status_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_q));
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q));
endmodule

// File: rtl/smb_read_mux.sv
module smb_read_mux
  import smb_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_dir,
  input  logic        stop,
  input  logic        rd_req,
  input  logic        host_nack,
  input  logic [7:0]  status,
  input  logic [31:0] rdata,
  output logic        tx_vld,
  output logic [7:0]  tx_byte
);
  localparam int NBYTES = 1 + DATA_BYTES;
  localparam int IW     = $clog2(NBYTES + 1);

  logic          act_q, act_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          tv_q, tv_d;
  logic [7:0]    tb_q, tb_d;
  logic [7:0]    sel [NBYTES];

  assign sel[0] = status;
  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_sel
    assign sel[g+1] = rdata[8*g +: 8];
  end

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    tv_d  = 1'b0;
    tb_d  = tb_q;
    if (start) begin
      act_d = rd_dir;
      idx_d = '0;
    end else if (stop || host_nack) begin
      act_d = 1'b0;
    end else if (rd_req) begin
      tv_d = 1'b1;
      tb_d = 8'hFF;
      if (act_q && int'(idx_q) < NBYTES) begin
        tb_d  = sel[idx_q];
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      tv_q  <= 1'b0;
      tb_q  <= 8'hFF;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      tv_q  <= tv_d;
      tb_q  <= tb_d;
    end
  end

  assign tx_vld  = tv_q;
  assign tx_byte = tb_q;

  p_tx_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tv_q |-> $past(rd_req));
  p_idle_after_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_nack && !start) |=> !act_q);
endmodule

// File: rtl/smb_reg_bridge.sv
module smb_reg_bridge
  import smb_bridge_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int TMO_US = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fe_start,
  input  logic        fe_rd_dir,
  input  logic        fe_stop,
  input  logic        fe_byte_vld,
  input  logic [7:0]  fe_byte,
  output logic        fe_ack_vld,
  output logic        fe_ack_nack,
  output logic        fe_stretch,
  input  logic        fe_rd_req,
  input  logic        fe_host_nack,
  output logic        fe_tx_vld,
  output logic [7:0]  fe_tx_byte,
  output logic        ib_req_vld,
  output logic        ib_req_we,
  output logic [1:0]  ib_req_space,
  output logic [7:0]  ib_req_dest,
  output logic [11:0] ib_req_addr,
  output logic [31:0] ib_req_wdata,
  input  logic        ib_rsp_vld,
  input  logic [1:0]  ib_rsp_err,
  input  logic [31:0] ib_rsp_rdata
);
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TMO_US;

  // Reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  logic              b_ack, b_nack, fire;
  logic              f_we;
  logic [1:0]        f_space;
  logic [7:0]        f_dest;
  logic [ADDR_W-1:0] f_addr;
  logic [31:0]       f_wdata;
  logic              busy, done, done_nack;
  logic [7:0]        status;
  logic [31:0]       rdata;
  logic              ack_q, nack_q;

  smb_setup_collect u_collect (
    .clk        (clk),
    .rst_n      (rs2_q),
    .frame_edge (fe_start || fe_stop),
    .byte_vld   (fe_byte_vld),
    .byte_in    (fe_byte),
    .byte_ack   (b_ack),
    .byte_nack  (b_nack),
    .fire_q     (fire),
    .f_we       (f_we),
    .f_space    (f_space),
    .f_dest     (f_dest),
    .f_addr     (f_addr),
    .f_wdata    (f_wdata)
  );

  smb_access_ctl #(.TMO_CYC(TMO_CYC)) u_access (
    .clk       (clk),
    .rst_n     (rs2_q),
    .fire      (fire),
    .f_we      (f_we),
    .f_space   (f_space),
    .f_dest    (f_dest),
    .f_addr    (f_addr),
    .f_wdata   (f_wdata),
    .rsp_vld   (ib_rsp_vld),
    .rsp_err   (ib_rsp_err),
    .rsp_rdata (ib_rsp_rdata),
    .req_vld   (ib_req_vld),
    .req_we    (ib_req_we),
    .req_space (ib_req_space),
    .req_dest  (ib_req_dest),
    .req_addr  (ib_req_addr),
    .req_wdata (ib_req_wdata),
    .busy      (busy),
    .done      (done),
    .done_nack (done_nack),
    .status    (status),
    .rdata     (rdata)
  );

  smb_read_mux u_rdmux (
    .clk       (clk),
    .rst_n     (rs2_q),
    .start     (fe_start),
    .rd_dir    (fe_rd_dir),
    .stop      (fe_stop),
    .rd_req    (fe_rd_req),
    .host_nack (fe_host_nack),
    .status    (status),
    .rdata     (rdata),
    .tx_vld    (fe_tx_vld),
    .tx_byte   (fe_tx_byte)
  );

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) begin
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      ack_q  <= b_ack;
      nack_q <= b_nack;
    end
  end

  assign fe_ack_vld  = ack_q || done;
  assign fe_ack_nack = ack_q ? nack_q : done_nack;
  assign fe_stretch  = fire || busy;

  p_no_ack_in_stretch_r5: assert property (@(posedge clk) disable iff (!rs2_q)
    fe_stretch |-> !fe_ack_vld);
  p_stretch_follows_fire_r5: assert property (@(posedge clk) disable iff (!rs2_q)
    $rose(ib_req_vld) |-> fe_stretch);
endmodule

// File: tb/smb_reg_bridge_tb.sv
module smb_reg_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 1_000_000;
  localparam int TB_TMO_US  = 20;
  localparam int TMO        = (TB_CLK_HZ / 1_000_000) * TB_TMO_US;
  localparam int RSP_DLY    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe_start = 1'b0, fe_rd_dir = 1'b0, fe_stop = 1'b0;
  logic        fe_byte_vld = 1'b0;
  logic [7:0]  fe_byte = '0;
  logic        fe_ack_vld, fe_ack_nack, fe_stretch;
  logic        fe_rd_req = 1'b0, fe_host_nack = 1'b0;
  logic        fe_tx_vld;
  logic [7:0]  fe_tx_byte;
  logic        ib_req_vld, ib_req_we;
  logic [1:0]  ib_req_space;
  logic [7:0]  ib_req_dest;
  logic [11:0] ib_req_addr;
  logic [31:0] ib_req_wdata;
  logic        ib_rsp_vld = 1'b0;
  logic [1:0]  ib_rsp_err = '0;
  logic [31:0] ib_rsp_rdata = '0;

  smb_reg_bridge #(.CLK_HZ(TB_CLK_HZ), .TMO_US(TB_TMO_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .fe_start(fe_start), .fe_rd_dir(fe_rd_dir),
    .fe_stop(fe_stop), .fe_byte_vld(fe_byte_vld), .fe_byte(fe_byte),
    .fe_ack_vld(fe_ack_vld), .fe_ack_nack(fe_ack_nack), .fe_stretch(fe_stretch),
    .fe_rd_req(fe_rd_req), .fe_host_nack(fe_host_nack), .fe_tx_vld(fe_tx_vld),
    .fe_tx_byte(fe_tx_byte), .ib_req_vld(ib_req_vld), .ib_req_we(ib_req_we),
    .ib_req_space(ib_req_space), .ib_req_dest(ib_req_dest), .ib_req_addr(ib_req_addr),
    .ib_req_wdata(ib_req_wdata), .ib_rsp_vld(ib_rsp_vld), .ib_rsp_err(ib_rsp_err),
    .ib_rsp_rdata(ib_rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Responder model
  int          nreq = 0, req_cyc = 0, rsp_cyc = 0;
  bit          rsp_drop = 1'b0;
  logic [1:0]  rsp_err_cfg = '0;
  logic [31:0] rsp_data_cfg = '0;
  logic        cap_we;
  logic [1:0]  cap_sp;
  logic [7:0]  cap_dest;
  logic [11:0] cap_addr;
  logic [31:0] cap_wd;

  initial begin
    forever begin
      @(negedge clk);
      if (ib_req_vld) begin
        nreq++;
        req_cyc  = cyc;
        cap_we   = ib_req_we;
        cap_sp   = ib_req_space;
        cap_dest = ib_req_dest;
        cap_addr = ib_req_addr;
        cap_wd   = ib_req_wdata;
        repeat (RSP_DLY) @(negedge clk);
        if (!rsp_drop) begin
          ib_rsp_vld   = 1'b1;
          ib_rsp_err   = rsp_err_cfg;
          ib_rsp_rdata = rsp_data_cfg;
          rsp_cyc      = cyc;
          @(negedge clk);
          ib_rsp_vld = 1'b0;
        end
      end
    end
  end

  int c0_g, ack_cyc_g;
  bit st_seen_g, st_at_ack_g, got_ack_g;

  task automatic frame(input bit is_start, input bit rd);
    @(negedge clk);
    fe_start = is_start; fe_stop = !is_start; fe_rd_dir = rd;
    @(negedge clk);
    fe_start = 1'b0; fe_stop = 1'b0; fe_rd_dir = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nk);
    @(negedge clk);
    fe_byte = b; fe_byte_vld = 1'b1; c0_g = cyc;
    @(negedge clk);
    fe_byte_vld = 1'b0;
    st_seen_g = 1'b0; got_ack_g = 1'b0; nk = 1'b1;
    for (int i = 0; i < 200 && !got_ack_g; i++) begin
      if (fe_ack_vld) begin
        got_ack_g = 1'b1; nk = fe_ack_nack; ack_cyc_g = cyc; st_at_ack_g = fe_stretch;
      end else begin
        if (fe_stretch) st_seen_g = 1'b1;
        @(negedge clk);
      end
    end
  endtask

  task automatic rd_byte(output logic [7:0] b, output logic v);
    @(negedge clk);
    fe_rd_req = 1'b1;
    @(negedge clk);
    fe_rd_req = 1'b0;
    v = fe_tx_vld; b = fe_tx_byte;
  endtask

  task automatic host_nack();
    @(negedge clk);
    fe_host_nack = 1'b1;
    @(negedge clk);
    fe_host_nack = 1'b0;
  endtask

  // Read status and four data bytes, check against expectations
  task automatic read_back(input logic [7:0] exp_st, input logic [31:0] exp_d, input string tag);
    logic [7:0]  b;
    logic        v;
    logic [31:0] got;
    frame(1'b1, 1'b1);
    rd_byte(b, v);
    chk(v && b == exp_st, {tag, " R9 status byte"}, {24'h0, b}, {24'h0, exp_st});
    got = '0;
    for (int k = 0; k < 4; k++) begin
      rd_byte(b, v);
      got[8*k +: 8] = b;
    end
    chk(got == exp_d, {tag, " R9 read data"}, got, exp_d);
    host_nack();
    frame(1'b0, 1'b0);
  endtask

  // Vector: mem, rd, p0..p3, wdata, err, rsp data, expected addr
  localparam int VW = 112;
  localparam int NV = 6;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h34, 8'hF2, 8'h00, 8'h00, 32'hDEADBEEF, 2'd0, 32'h00000000, 12'h234},
    {1'b0, 1'b1, 8'h10, 8'hA0, 8'h00, 8'h00, 32'h00000000, 2'd0, 32'h11223344, 12'h010},
    {1'b1, 1'b1, 8'h05, 8'hAB, 8'hC7, 8'h89, 32'h00000000, 2'd0, 32'hCAFEF00D, 12'h789},
    {1'b1, 1'b0, 8'h02, 8'h12, 8'h34, 8'h56, 32'h01020304, 2'd1, 32'h00000000, 12'h456},
    {1'b0, 1'b1, 8'h44, 8'h03, 8'h00, 8'h00, 32'h00000000, 2'd2, 32'h55555555, 12'h344},
    {1'b1, 1'b0, 8'h09, 8'hFF, 8'hF1, 8'h23, 32'hA5A55A5A, 2'd0, 32'h00000000, 12'h123}
  };

  logic [31:0] exp_rd = '0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic nk;
    logic [7:0] b;
    logic v;
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(!ib_req_vld && !fe_stretch && !fe_ack_vld, "R11 idle outputs",
        {29'h0, ib_req_vld, fe_stretch, fe_ack_vld}, 32'h0);
    read_back(8'h00, 32'h0, "R11");

    // Table walk: one block write with End per vector
    for (int vi = 0; vi < NV; vi++) begin
      logic [VW-1:0] t;
      logic          mem, rd;
      logic [7:0]    p [4];
      logic [31:0]   wd, rdat;
      logic [1:0]    err;
      logic [11:0]   ea;
      logic [7:0]    exp_st;
      int            np;
      bit            pre_ok;
      int            nreq0;
      t = VEC[vi];
      mem = t[111]; rd = t[110];
      p[0] = t[109:102]; p[1] = t[101:94]; p[2] = t[93:86]; p[3] = t[85:78];
      wd = t[77:46]; err = t[45:44]; rdat = t[43:12]; ea = t[11:0];
      np = mem ? 4 : 2;
      rsp_err_cfg = err; rsp_data_cfg = rdat;
      nreq0 = nreq;
      pre_ok = 1'b1;
      frame(1'b1, 1'b0);
      send_byte({1'b1, 1'b1, 3'b000, mem, 1'b0, rd}, nk);
      pre_ok &= got_ack_g && !nk;
      send_byte(8'(rd ? np : np + 4), nk);
      pre_ok &= got_ack_g && !nk;
      for (int k = 0; k < np; k++) begin
        send_byte(p[k], nk);
        if (!(rd && k == np - 1)) pre_ok &= got_ack_g && !nk && (ack_cyc_g - c0_g == 1);
      end
      if (!rd) for (int k = 0; k < 4; k++) begin
        send_byte(wd[8*k +: 8], nk);
        if (k != 3) pre_ok &= got_ack_g && !nk && (ack_cyc_g - c0_g == 1);
      end
      frame(1'b0, 1'b0);
      chk(pre_ok, "R3 earlier bytes acked next cycle", {31'h0, pre_ok}, 32'h1);
      chk(nreq == nreq0 + 1 && req_cyc - c0_g == 2, "R4 one request two cycles after last byte",
          32'(req_cyc - c0_g), 32'd2);
      chk(cap_addr == ea, mem ? "R2 memory address" : "R1 config address",
          {20'h0, cap_addr}, {20'h0, ea});
      chk(cap_sp == {1'b0, mem} && cap_we == !rd, "R1 R2 space and direction",
          {29'h0, cap_sp, cap_we}, {29'h0, 1'b0, mem, !rd});
      chk(cap_dest == (mem ? p[0] : 8'h00), "R2 destination", {24'h0, cap_dest},
          {24'h0, mem ? p[0] : 8'h00});
      if (!rd) chk(cap_wd == wd, "R4 write data order", cap_wd, wd);
      chk(st_seen_g && !st_at_ack_g && ack_cyc_g == rsp_cyc + 1, "R5 stretch then ack",
          32'(ack_cyc_g - rsp_cyc), 32'd1);
      chk(got_ack_g && nk == (err != 2'd0), "R6 final ack/nack", {31'h0, nk}, {31'h0, err != 2'd0});
      exp_st = (err == 2'd0) ? 8'h01 : (err == 2'd1) ? 8'h10 : 8'h20;
      if (rd && err == 2'd0) exp_rd = rdat;
      read_back(exp_st, exp_rd, "R6");
    end

    // R3: parameters across byte, word and block writes
    n0 = nreq;
    frame(1'b1, 1'b0); send_byte(8'h00, nk); send_byte(8'h77, nk); frame(1'b0, 1'b0);
    frame(1'b1, 1'b0); send_byte(8'h00, nk); send_byte(8'hE5, nk); send_byte(8'h11, nk); frame(1'b0, 1'b0);
    chk(nreq == n0, "R3 no request before End", 32'(nreq - n0), 32'd0);
    rsp_err_cfg = 2'd0;
    frame(1'b1, 1'b0); send_byte(8'hC0, nk); send_byte(8'h03, nk);
    send_byte(8'h22, nk); send_byte(8'h33, nk); send_byte(8'h44, nk); frame(1'b0, 1'b0);
    chk(nreq == n0 + 1 && cap_addr == 12'h577 && cap_wd == 32'h44332211, "R3 mixed writes assemble",
        cap_wd, 32'h44332211);

    // R4: End write carrying only the command byte launches
    rsp_data_cfg = 32'h87654321;
    frame(1'b1, 1'b0); send_byte(8'h01, nk); send_byte(8'h08, nk); frame(1'b0, 1'b0);
    frame(1'b1, 1'b0); send_byte(8'h01, nk); send_byte(8'h00, nk); frame(1'b0, 1'b0);
    n0 = nreq;
    frame(1'b1, 1'b0); send_byte(8'h81, nk); frame(1'b0, 1'b0);
    chk(nreq == n0 + 1 && cap_addr == 12'h008 && req_cyc - c0_g == 2, "R4 launch on command byte",
        {20'h0, cap_addr}, 32'h008);
    exp_rd = 32'h87654321;
    read_back(8'h01, exp_rd, "R4");

    // R8: mismatched internal command nacked and setup discarded
    frame(1'b1, 1'b0); send_byte(8'h00, nk); send_byte(8'h12, nk); frame(1'b0, 1'b0);
    frame(1'b1, 1'b0); send_byte(8'h01, nk);
    chk(got_ack_g && nk, "R8 mismatch command nacked", {31'h0, nk}, 32'h1);
    send_byte(8'h55, nk);
    chk(got_ack_g && nk, "R8 rest of rejected write nacked", {31'h0, nk}, 32'h1);
    frame(1'b0, 1'b0);
    n0 = nreq;
    frame(1'b1, 1'b0); send_byte(8'h81, nk); frame(1'b0, 1'b0);
    chk(nreq == n0 && !nk, "R8 discarded setup does not launch", 32'(nreq - n0), 32'd0);
    frame(1'b1, 1'b0); send_byte(8'h01, nk); send_byte(8'h09, nk); send_byte(8'h00, nk); frame(1'b0, 1'b0);
    frame(1'b1, 1'b0); send_byte(8'h81, nk); frame(1'b0, 1'b0);
    chk(nreq == n0 + 1 && cap_addr == 12'h009, "R8 fresh setup after discard",
        {20'h0, cap_addr}, 32'h009);
    frame(1'b1, 1'b0); send_byte(8'h08, nk); frame(1'b0, 1'b0);
    chk(got_ack_g && nk, "R8 reserved space nacked", {31'h0, nk}, 32'h1);

    // R7: timeout
    rsp_drop = 1'b1;
    frame(1'b1, 1'b0); send_byte(8'hC1, nk); send_byte(8'h02, nk);
    send_byte(8'h20, nk); send_byte(8'h00, nk); frame(1'b0, 1'b0);
    chk(got_ack_g && nk && (ack_cyc_g - c0_g == TMO + 2), "R7 timeout nack latency",
        32'(ack_cyc_g - c0_g), 32'(TMO + 2));
    repeat (RSP_DLY + 2) @(negedge clk);
    rsp_drop = 1'b0;
    read_back(8'h80, exp_rd, "R7");

    // R9 bytes beyond five, R10 host nack ends data
    frame(1'b1, 1'b1);
    for (int k = 0; k < 5; k++) rd_byte(b, v);
    rd_byte(b, v);
    chk(v && b == 8'hFF, "R9 byte past data is FF", {24'h0, b}, 32'hFF);
    frame(1'b0, 1'b0);
    frame(1'b1, 1'b1);
    rd_byte(b, v);
    chk(b == 8'h80, "R10 status before host nack", {24'h0, b}, 32'h80);
    host_nack();
    rd_byte(b, v);
    chk(v && b == 8'hFF, "R10 idle after host nack", {24'h0, b}, 32'hFF);
    frame(1'b0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule